// File: doc/BRIEF.md
# Serial Management Interface Master

This block is a register-programmed master for the two-wire management bus that connects a MAC to up to 32 PHYs. Software programs a 32-bit command word holding an opcode, a PHY address, a register address and sixteen bits of write data. Setting the go bit in the same write launches one Clause 22 frame. While the frame runs, the go bit reads back as 1. When the frame ends, the go bit drops to 0, and a read frame leaves the returned sixteen bits in the low half of the same word. A second word selects the management clock divider, with MDC = ref / (2 x (div + 1)), and can drop the 32-bit preamble.

The sequencer steps through five named states:
- ST_IDLE: the bus is released and MDC is parked high.
- ST_PRE: 32 preamble ones.
- ST_HDR: start pattern 01, two opcode bits, five PHY address bits and five register address bits, MSB first.
- ST_TA: two turnaround bits.
- ST_DATA: sixteen data bits, MSB first.

The transitions, each taken on the MDC rise that completes the last bit of a state, are:
- T_LAUNCH: ST_IDLE to ST_PRE, or to ST_HDR when the preamble is dropped, on an accepted go write.
- T_PRE_DONE: ST_PRE to ST_HDR.
- T_HDR_DONE: ST_HDR to ST_TA.
- T_TA_DONE: ST_TA to ST_DATA.
- T_FRAME_END: ST_DATA to ST_IDLE.

The master changes MDIO only as MDC falls and samples MDIO as MDC rises. For a read (opcode 10), it releases MDIO from the first turnaround bit to the end of the frame. A 1 seen on the second turnaround bit raises the read-fail flag.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset, the command word (byte offset 0x00) reads 0 and the configuration word (offset 0x04) reads with bit 0 = 1, divider bits 9:4 = DIV_RST (default 9) and bit 12 = 0. MDC is high and MDIO is not driven.
- R2: Writing the command word with bit 29 = 1 while idle starts a frame. Bit 29 reads 1 from the next cycle until the frame ends, and then reads 0.
- R3: Writes to either word while bit 29 reads 1 are ignored. The command fields and the configuration keep their earlier values.
- R4: While a frame runs, MDC is low for div + 1 reference cycles in each bit, where div is taken from configuration bits 9:4. Outside a frame, MDC stays high.
- R5: A frame sends 32 ones, then 01, the opcode from command bits 27:26, the PHY address from bits 25:21 and the register address from bits 20:16, all MSB first. A write frame (any opcode other than 10) then sends turnaround 10 and data bits 15:0, MSB first.
- R6: With configuration bit 12 = 1, the 32 preamble ones are left out and the frame begins with the start pattern.
- R7: In a read frame (opcode 10), MDIO is released during both turnaround bits and all data bits. The sixteen bits sampled on the MDC rises of the data phase, first bit as MSB, appear in command bits 15:0 once bit 29 reads 0.
- R8: Command bit 28 reads 1 after a read frame in which MDIO was 1 at the second turnaround bit, and reads 0 otherwise. It is cleared when a frame starts, and software cannot write it.
- R9: MDIO output data and a rise of the output enable change only in the reference cycle in which MDC falls.
- R10: A frame of N bits (64, or 32 without preamble) keeps bit 29 at 1 for exactly 2 x N x (div + 1) reference cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | Write enable for the access |
| bus_addr | input | ADDR_W | Byte address: 0x00 command, 0x04 configuration |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input value |

## Verification
Two functions can fall in the same reference cycle. The first is software rewriting the command or configuration word. The second is the sequencer using those fields in the middle of a frame. The bench provokes this by issuing a go write with a different PHY address, and then a divider change, a few cycles after launch. It judges the result by checking that the bits on the wire, the frame length and the read-back words all match the first command. The same cycle also carries the final MDC rise, the clearing of the go bit and the capture of read data and read-fail. The bench checks that the last data bit is captured and that the result is visible on the first cycle the go bit reads 0.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
    localparam int PHY_W   = 5;
    localparam int RA_W    = 5;
    localparam int DAT_W   = 16;
    localparam int OP_W    = 2;
    localparam int HDR_W   = 2 + OP_W + PHY_W + RA_W;
    localparam logic [OP_W-1:0] OP_RD = 2'b10;

    // command word bit positions
    localparam int GO_BIT   = 29;
    localparam int FAIL_BIT = 28;
    localparam int OP_LSB   = 26;
    localparam int PHY_LSB  = 21;
    localparam int RA_LSB   = 16;

    // configuration word bit positions
    localparam int C22_BIT  = 0;
    localparam int DIV_LSB  = 4;
    localparam int NOPRE_BIT = 12;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_HDR,
        ST_TA,
        ST_DATA
    } mgmt_state_e;
endpackage

// File: rtl/mgmt_clkdiv.sv
module mgmt_clkdiv #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             fall_evt,
    output logic             rise_evt
);
    logic [DIV_W-1:0] cnt_q;
    logic             mdc_q;
    logic             wrap;

    assign wrap     = run && (cnt_q == div);
    assign fall_evt = wrap && mdc_q;
    assign rise_evt = wrap && !mdc_q;
    assign mdc      = mdc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mdc_q <= 1'b1;
        end else if (!run) begin
            cnt_q <= '0;
            mdc_q <= 1'b1;
        end else if (wrap) begin
            cnt_q <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             no_pre,
    input  logic [OP_W-1:0]  op,
    input  logic [PHY_W-1:0] phy,
    input  logic [RA_W-1:0]  regad,
    input  logic [DAT_W-1:0] wdata,
    input  logic             mdio_i,
    input  logic             fall_evt,
    input  logic             rise_evt,
    output logic             mdio_o,
    output logic             mdio_oe,
    output logic             done,
    output logic [DAT_W-1:0] rd_data,
    output logic             ta_bad
);
    localparam int CNT_MAX = (PRE_LEN > DAT_W) ? PRE_LEN : DAT_W;
    localparam int CNT_W   = $clog2(CNT_MAX);

    mgmt_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [HDR_W-1:0] hdr;
    logic             is_rd;
    logic             last_bit;
    logic [DAT_W-1:0] sh_q;
    logic             o_q, oe_q, bad_q;

    assign hdr      = {2'b01, op, phy, regad};
    assign is_rd    = (op == OP_RD);
    assign last_bit = (cnt_q == '0);
    assign done     = rise_evt && (state_q == ST_DATA) && last_bit;
    assign rd_data  = {sh_q[DAT_W-2:0], mdio_i};
    assign mdio_o   = o_q;
    assign mdio_oe  = oe_q;
    assign ta_bad   = bad_q;

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (no_pre) begin
                        state_d = ST_HDR;
                        cnt_d   = CNT_W'(HDR_W - 1);
                    end else begin
                        state_d = ST_PRE;
                        cnt_d   = CNT_W'(PRE_LEN - 1);
                    end
                end
            end
            ST_PRE: begin
                if (rise_evt) begin
                    if (last_bit) begin
                        state_d = ST_HDR;
                        cnt_d   = CNT_W'(HDR_W - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_HDR: begin
                if (rise_evt) begin
                    if (last_bit) begin
                        state_d = ST_TA;
                        cnt_d   = CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_TA: begin
                if (rise_evt) begin
                    if (last_bit) begin
                        state_d = ST_DATA;
                        cnt_d   = CNT_W'(DAT_W - 1);
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_DATA: begin
                if (rise_evt) begin
                    if (last_bit) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs: drive on MDC fall, sample on MDC rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q   <= 1'b1;
            oe_q  <= 1'b0;
            sh_q  <= '0;
            bad_q <= 1'b0;
        end else begin
            if (start) begin
                bad_q <= 1'b0;
            end
            if (fall_evt) begin
                unique case (state_q)
                    ST_PRE: begin
                        o_q  <= 1'b1;
                        oe_q <= 1'b1;
                    end
                    ST_HDR: begin
                        o_q  <= hdr[cnt_q];
                        oe_q <= 1'b1;
                    end
                    ST_TA: begin
                        if (is_rd) begin
                            oe_q <= 1'b0;
                        end else begin
                            o_q  <= cnt_q[0];
                            oe_q <= 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (is_rd) begin
                            oe_q <= 1'b0;
                        end else begin
                            o_q  <= wdata[cnt_q[3:0]];
                            oe_q <= 1'b1;
                        end
                    end
                    default: oe_q <= 1'b0;
                endcase
            end else if (state_q == ST_IDLE && !start) begin
                oe_q <= 1'b0;
            end
            if (rise_evt && is_rd) begin
                if (state_q == ST_TA && last_bit) begin
                    bad_q <= mdio_i;
                end
                if (state_q == ST_DATA) begin
                    sh_q <= {sh_q[DAT_W-2:0], mdio_i};
                end
            end
        end
    end
endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int          ADDR_W  = 3,
    parameter int          DIV_W   = 6,
    parameter logic [5:0]  DIV_RST = 6'd9,
    parameter int          PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    localparam logic [ADDR_W-1:0] CMD_OFS = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] CFG_OFS = ADDR_W'(4);

    logic [OP_W-1:0]  cmd_op_q;
    logic [PHY_W-1:0] cmd_phy_q;
    logic [RA_W-1:0]  cmd_ra_q;
    logic [DAT_W-1:0] cmd_dat_q;
    logic             busy_q, fail_q;
    logic             cfg_c22_q, cfg_nopre_q;
    logic [DIV_W-1:0] cfg_div_q;

    logic             wr_cmd, wr_cfg, start;
    logic             fall_evt, rise_evt, done, ta_bad;
    logic [DAT_W-1:0] rd_data;
    logic             unused_wbits;

    assign wr_cmd = bus_en && bus_we && !busy_q && (bus_addr == CMD_OFS);
    assign wr_cfg = bus_en && bus_we && !busy_q && (bus_addr == CFG_OFS);
    assign start  = wr_cmd && bus_wdata[GO_BIT];
    assign unused_wbits = ^{bus_wdata[31:30], bus_wdata[FAIL_BIT]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_op_q    <= '0;
            cmd_phy_q   <= '0;
            cmd_ra_q    <= '0;
            cmd_dat_q   <= '0;
            busy_q      <= 1'b0;
            fail_q      <= 1'b0;
            cfg_c22_q   <= 1'b1;
            cfg_nopre_q <= 1'b0;
            cfg_div_q   <= DIV_W'(DIV_RST);
        end else begin
            if (wr_cmd) begin
                cmd_op_q  <= bus_wdata[OP_LSB +: OP_W];
                cmd_phy_q <= bus_wdata[PHY_LSB +: PHY_W];
                cmd_ra_q  <= bus_wdata[RA_LSB +: RA_W];
                cmd_dat_q <= bus_wdata[DAT_W-1:0];
                if (bus_wdata[GO_BIT]) begin
                    busy_q <= 1'b1;
                    fail_q <= 1'b0;
                end
            end
            if (wr_cfg) begin
                cfg_c22_q   <= bus_wdata[C22_BIT];
                cfg_nopre_q <= bus_wdata[NOPRE_BIT];
                cfg_div_q   <= bus_wdata[DIV_LSB +: DIV_W];
            end
            if (done) begin
                busy_q <= 1'b0;
                if (cmd_op_q == OP_RD) begin
                    cmd_dat_q <= rd_data;
                    fail_q    <= ta_bad;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CMD_OFS) begin
            bus_rdata[GO_BIT]              = busy_q;
            bus_rdata[FAIL_BIT]            = fail_q;
            bus_rdata[OP_LSB +: OP_W]      = cmd_op_q;
            bus_rdata[PHY_LSB +: PHY_W]    = cmd_phy_q;
            bus_rdata[RA_LSB +: RA_W]      = cmd_ra_q;
            bus_rdata[DAT_W-1:0]           = cmd_dat_q;
        end else if (bus_addr == CFG_OFS) begin
            bus_rdata[C22_BIT]             = cfg_c22_q;
            bus_rdata[NOPRE_BIT]           = cfg_nopre_q;
            bus_rdata[DIV_LSB +: DIV_W]    = cfg_div_q;
        end
    end

    mgmt_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy_q),
        .div      (cfg_div_q),
        .mdc      (mdc),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt)
    );

    mgmt_frame_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .no_pre   (cfg_nopre_q),
        .op       (cmd_op_q),
        .phy      (cmd_phy_q),
        .regad    (cmd_ra_q),
        .wdata    (cmd_dat_q),
        .mdio_i   (mdio_i),
        .fall_evt (fall_evt),
        .rise_evt (rise_evt),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (rd_data),
        .ta_bad   (ta_bad)
    );
endmodule

// File: rtl/mgmt_master_chk.sv
module mgmt_master_chk #(
    parameter int PHY_W = 5,
    parameter int DIV_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             fail,
    input logic             mdc,
    input logic             oe,
    input logic [PHY_W-1:0] phy,
    input logic [DIV_W-1:0] div
);
    p_mdc_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> mdc);

    p_mdc_moves_in_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdc) |-> $past(busy));

    p_start_clears_fail_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !fail);

    p_fail_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $fell(busy));

    p_fields_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(phy) && $stable(div)));

    p_oe_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !mdc);
endmodule

bind mgmt_serial_master mgmt_master_chk #(.PHY_W(5), .DIV_W(DIV_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_q),
    .fail  (fail_q),
    .mdc   (mdc),
    .oe    (mdio_oe),
    .phy   (cmd_phy_q),
    .div   (cfg_div_q)
);

// File: tb/sim_mgmt_serial_master.sv
module sim_mgmt_serial_master;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mgmt_serial_master u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cfg_word(input logic [5:0] dv, input logic np);
        return {19'b0, np, 2'b0, dv, 3'b0, 1'b1};
    endfunction

    // expected {oe, value} of transmitted bit idx
    function automatic logic [1:0] exp_bit(input int idx, input int pre, input logic [1:0] op,
                                           input logic [4:0] phy, input logic [4:0] ra,
                                           input logic [15:0] d);
        logic [13:0] h;
        int j;
        h = {2'b01, op, phy, ra};
        j = idx - pre;
        if (j < 0) return 2'b11;
        if (j < 14) return {1'b1, h[13-j]};
        if (op == 2'b10) return 2'b00;
        if (j < 16) return {1'b1, (j == 14)};
        return {1'b1, d[31-j]};
    endfunction

    function automatic logic phy_bit(input int idx, input int pre, input logic ta2,
                                     input logic [15:0] resp);
        int j;
        j = idx - pre;
        if (j == 15) return ta2;
        if (j >= 16 && j < 32) return resp[31-j];
        return 1'b1;
    endfunction

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0; bus_addr = 3'd0;
        #1;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
        bus_addr = 3'd0;
    endtask

    task automatic run_frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] d, input logic np, input logic [5:0] dv,
                             input logic [15:0] resp, input logic ta2, input logic inject);
        int pre, nb, busy_cnt, low_cnt, idx, cyc;
        logic prev_mdc, prev_o, r9_bad, b, skip, rd;
        logic [63:0] cap_v, cap_oe;
        logic [31:0] rb;
        int bit_bad;
        pre = np ? 0 : 32;
        nb = pre + 32;
        rd = (op == 2'b10);
        busy_cnt = 0; low_cnt = 0; idx = 0; cyc = 0;
        prev_mdc = 1'b1; r9_bad = 1'b0; skip = 1'b0;
        cap_v = '0; cap_oe = '0;
        mdio_i = 1'b1;
        bus_write(3'd4, cfg_word(dv, np));
        bus_write(3'd0, {2'b00, 1'b1, 1'b0, op, phy, ra, d});
        prev_o = mdio_o;
        chk("R2 busy after go", {31'b0, bus_rdata[29]}, 32'd1);
        while (cyc < 20000) begin
            b = skip ? 1'b1 : bus_rdata[29];
            if (mdc && !prev_mdc) begin
                if (idx < 64) begin
                    cap_v[idx]  = mdio_o;
                    cap_oe[idx] = mdio_oe;
                end
                idx++;
            end
            if (!b) break;
            busy_cnt++;
            if (!mdc) low_cnt++;
            if (!mdc && prev_mdc) mdio_i = phy_bit(idx, pre, ta2, resp);
            if ((mdio_o !== prev_o) && !(!mdc && prev_mdc)) r9_bad = 1'b1;
            prev_mdc = mdc;
            prev_o = mdio_o;
            @(negedge clk);
            cyc++;
            skip = 1'b0;
            bus_en = 1'b0; bus_we = 1'b0; bus_addr = 3'd0;
            if (inject && cyc == 3) begin
                // R3: go write with other fields while busy
                bus_en = 1'b1; bus_we = 1'b1;
                bus_wdata = {2'b00, 1'b1, 1'b0, ~op, ~phy, ~ra, ~d};
            end else if (inject && cyc == 4) begin
                bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd4;
                bus_wdata = cfg_word(dv + 6'd5, ~np);
                skip = 1'b1;
            end
            #1;
        end
        mdio_i = 1'b1;
        chk("R10 busy length", busy_cnt, 2 * nb * (dv + 1));
        chk("R4 mdc low cycles", low_cnt, nb * (dv + 1));
        chk(np ? "R6 bit count" : "R5 bit count", idx, nb);
        bit_bad = 0;
        for (int i = 0; i < nb; i++) begin
            logic [1:0] e;
            e = exp_bit(i, pre, op, phy, ra, d);
            if (cap_oe[i] !== e[1]) bit_bad++;
            else if (e[1] && cap_v[i] !== e[0]) bit_bad++;
        end
        chk(rd ? "R7 wire bits" : (np ? "R6 wire bits" : "R5 wire bits"), bit_bad, 0);
        chk("R9 mdio changes on MDC fall", {31'b0, r9_bad}, 32'd0);
        chk("R4 mdc high after frame", {31'b0, mdc}, 32'd1);
        bus_read(3'd0, rb);
        chk("R2 busy cleared", {31'b0, rb[29]}, 32'd0);
        chk("R8 fail flag", {31'b0, rb[28]}, {31'b0, rd && ta2});
        chk(rd ? "R7 read data" : "R3 data field", {16'b0, rb[15:0]}, {16'b0, rd ? resp : d});
        chk("R3 cmd fields", {21'b0, rb[27:16]}, {21'b0, op, phy, ra});
        bus_read(3'd4, rb);
        chk("R3 cfg held", rb, cfg_word(dv, np));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rb;
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        #1;
        chk("R1 mdc at reset", {31'b0, mdc}, 32'd1);
        chk("R1 oe at reset", {31'b0, mdio_oe}, 32'd0);
        rst_n = 1'b1;
        bus_read(3'd0, rb);
        chk("R1 cmd reset", rb, 32'd0);
        bus_read(3'd4, rb);
        chk("R1 cfg reset", rb, cfg_word(6'd9, 1'b0));

        // R8: fail bit not writable
        bus_write(3'd0, 32'h1000_0000);
        bus_read(3'd0, rb);
        chk("R8 fail not writable", {31'b0, rb[28]}, 32'd0);

        // directed corners
        run_frame(2'b01, 5'h1F, 5'h00, 16'hA5C3, 1'b0, 6'd0, 16'h0, 1'b0, 1'b0);
        run_frame(2'b10, 5'h03, 5'h01, 16'h0000, 1'b0, 6'd1, 16'h8001, 1'b0, 1'b0);
        run_frame(2'b10, 5'h10, 5'h1F, 16'h0000, 1'b1, 6'd0, 16'h7FFE, 1'b1, 1'b0);
        // fail stays set against a software write of zero
        bus_write(3'd0, {2'b00, 1'b0, 1'b0, 2'b10, 5'h10, 5'h1F, 16'h0});
        bus_read(3'd0, rb);
        chk("R8 fail survives write", {31'b0, rb[28]}, 32'd1);
        // next frame clears it
        run_frame(2'b01, 5'h0A, 5'h15, 16'hFFFF, 1'b1, 6'd2, 16'h0, 1'b0, 1'b1);
        run_frame(2'b10, 5'h05, 5'h02, 16'h1234, 1'b0, 6'd3, 16'hBEEF, 1'b0, 1'b1);

        for (int k = 0; k < 16; k++) begin
            logic [1:0] op;
            op = ($urandom % 2) ? 2'b10 : 2'b01;
            run_frame(op, 5'($urandom), 5'($urandom), 16'($urandom), 1'($urandom),
                      6'($urandom % 4), 16'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule